// File: doc/BRIEF.md
# Even-Ratio Card Clock Divider

This block turns a fast PLL clock into the clock for a storage card controller. The output runs at the input frequency divided by an even ratio between 2 and 64, and its duty cycle is exactly 50%. An internal phase counter toggles the output each time it has counted the current half-period.

Software sets the ratio through a write port by giving the full divide value. A legal value is stored in halved-minus-one form as a 5-bit field `n`, so the ratio is `2*(n+1)`. A value that is odd, zero or above 64 is refused, raises a sticky error flag and leaves the stored field untouched. A new ratio takes effect only at the next output edge, so no phase is ever cut short.

A separate combinational helper takes a requested divide value and returns the nearest achievable even ratio at or above it. Drivers use it before they write.

Top module: `sdc_clk_div`

## Requirements
- R1: After reset the stored field `cfg_n_o` is 0, `clk_o` is low, `err_o` is low and the output divides by 2, so each phase lasts one input cycle.
- R2: With stored field n, every phase of `clk_o` lasts exactly n+1 input cycles. The period is therefore 2*(n+1) cycles and the duty cycle is 50%.
- R3: A write of an even ratio r with 2 <= r <= 64 sets `cfg_n_o` to r/2-1 from the next cycle on. This is the value r shifted right by one, minus one, held in 5 bits.
- R4: A write of an odd ratio sets `err_o` in the next cycle and leaves `cfg_n_o` unchanged.
- R5: A write of ratio 0, or of a ratio above 64, sets `err_o` in the next cycle and leaves `cfg_n_o` unchanged.
- R6: `err_o` remains set through any later rejected writes and clears in the cycle after the next accepted write.
- R7: A new ratio is applied at the next output toggle. The phase that is running when the write lands completes at its old length, and the following phase has the new length.
- R8: `rnd_ratio_o` equals `req_ratio_i` when that value is even, and `req_ratio_i`+1 when it is odd. It is combinational.
- R9: A rejected write leaves the phase length of `clk_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the ratio |
| wr_ratio_i | input | 7 | Requested full divide ratio |
| req_ratio_i | input | 7 | Divide value presented to the rounding helper |
| rnd_ratio_o | output | 8 | Nearest even ratio at or above `req_ratio_i` |
| cfg_n_o | output | 5 | Stored field n; the ratio is 2*(n+1) |
| clk_o | output | 1 | Divided clock |
| err_o | output | 1 | Sticky flag for a rejected write |

## Verification
The bench sweeps every legal ratio from 2 to 64 and checks the length of each phase. A design with an off-by-one in the halving would produce odd periods, and a wrapped field at ratio 64 would collapse the output to divide-by-2. Ratio changes are made in the middle of a phase, in both directions. A divider that reloaded its count at once would emit one clipped or stretched phase there.

Rejected values are also exercised: 0, 65, 66, odd values and the 7-bit maximum. A design that decoded any of these as legal would change the stored field or the output frequency, and one that cleared the error too eagerly would lose the sticky flag. Every one of the 128 possible inputs to the rounding helper is swept, so an error at 0 or at 127 would show.

// File: rtl/sdc_div_pkg.sv
package sdc_div_pkg;
  localparam int unsigned DEF_N_W = 5;

  typedef enum logic [1:0] {
    WR_OK    = 2'd0,
    WR_ODD   = 2'd1,
    WR_RANGE = 2'd2
  } wr_chk_e;
endpackage

// File: rtl/sdc_ratio_check.sv
module sdc_ratio_check
  import sdc_div_pkg::*;
#(
  parameter int unsigned N_W   = DEF_N_W,
  parameter int unsigned REQ_W = N_W + 2
) (
  input  logic [REQ_W-1:0] wr_ratio_i,
  input  logic [REQ_W-1:0] req_ratio_i,
  output wr_chk_e          chk_o,
  output logic [N_W-1:0]   n_new_o,
  output logic [REQ_W:0]   rnd_ratio_o
);
  localparam logic [REQ_W-1:0] MAX_RATIO = REQ_W'(2 ** (N_W + 1));

  always_comb begin
    if (wr_ratio_i == '0 || wr_ratio_i > MAX_RATIO) chk_o = WR_RANGE;
    else if (wr_ratio_i[0])                         chk_o = WR_ODD;
    else                                            chk_o = WR_OK;
  end

  // ratio 64 halves to 0 in N_W bits; minus one wraps to the top code
  assign n_new_o     = N_W'(wr_ratio_i[N_W:1] - 1'b1);
  assign rnd_ratio_o = {1'b0, req_ratio_i} + (REQ_W + 1)'(req_ratio_i[0]);
endmodule

// File: rtl/sdc_phase_gen.sv
module sdc_phase_gen #(
  parameter int unsigned N_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] pend_n_i,
  output logic           clk_o
);
  logic [N_W-1:0] cnt_q, act_q;
  logic           div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q == act_q) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      act_q <= pend_n_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = div_q;

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);
  a_r2_hold_mid_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(div_q));
  a_r7_load_at_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> (cnt_q == '0));
endmodule

// File: rtl/sdc_clk_div.sv
module sdc_clk_div
  import sdc_div_pkg::*;
#(
  parameter int unsigned N_W   = DEF_N_W,
  parameter int unsigned REQ_W = N_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REQ_W-1:0] wr_ratio_i,
  input  logic [REQ_W-1:0] req_ratio_i,
  output logic [REQ_W:0]   rnd_ratio_o,
  output logic [N_W-1:0]   cfg_n_o,
  output logic             clk_o,
  output logic             err_o
);
  wr_chk_e        chk;
  logic [N_W-1:0] n_new;
  logic [N_W-1:0] pend_q;
  logic           err_q;

  sdc_ratio_check #(.N_W(N_W), .REQ_W(REQ_W)) u_chk (
    .wr_ratio_i (wr_ratio_i),
    .req_ratio_i(req_ratio_i),
    .chk_o      (chk),
    .n_new_o    (n_new),
    .rnd_ratio_o(rnd_ratio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (chk == WR_OK) begin
        pend_q <= n_new;
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  sdc_phase_gen #(.N_W(N_W)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_n_i(pend_q),
    .clk_o   (clk_o)
  );

  assign cfg_n_o = pend_q;
  assign err_o   = err_q;

  a_r4_r5_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && chk != WR_OK) |=> $stable(pend_q));
  a_r6_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && chk != WR_OK) |=> err_q);
  a_r6_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && chk == WR_OK) |=> !err_q);
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !wr_en_i) |=> err_q);
  a_r8_round_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rnd_ratio_o[0] && rnd_ratio_o >= {1'b0, req_ratio_i});
endmodule

// File: tb/sdc_clk_div_test.sv
`timescale 1ns/1ps
module sdc_clk_div_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [6:0] wr_ratio_i = '0;
  logic [6:0] req_ratio_i = '0;
  logic [7:0] rnd_ratio_o;
  logic [4:0] cfg_n_o;
  logic       clk_o, err_o;

  int errors = 0, checks = 0;
  int toggles = 0, run = 0, last_len = 0;
  logic prev = 1'b0;
  bit done = 1'b0;

  sdc_clk_div uut (.*);

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      run = 0; prev = 1'b0;
    end else if (clk_o != prev) begin
      last_len = run; run = 1; toggles++; prev = clk_o;
    end else run++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int r);
    @(negedge clk_i); wr_en_i = 1'b1; wr_ratio_i = 7'(r);
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic wait_tog(input int k);
    int t = toggles;
    wait (toggles == t + k);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 clk_o low in reset", int'(clk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 cfg after reset", int'(cfg_n_o), 0);
    chk("R1 err after reset", int'(err_o), 0);
    wait_tog(3);
    chk("R1 divide by 2", last_len, 1);

    // R2 R3: sweep every legal even ratio
    for (int r = 2; r <= 64; r += 2) begin
      wr(r);
      chk("R3 stored field", int'(cfg_n_o), r / 2 - 1);
      chk("R6 err clear on valid", int'(err_o), 0);
      wait_tog(3);
      chk("R2 phase length", last_len, r / 2);
      wait_tog(1);
      chk("R2 phase length", last_len, r / 2);
    end

    // R7: mid-phase changes, both directions
    wr(8); wait_tog(3);
    wait_tog(1);
    wr(20);
    wait_tog(1); chk("R7 running phase keeps old length", last_len, 4);
    wait_tog(1); chk("R7 next phase new length", last_len, 10);
    wait_tog(1);
    wr(6);
    wait_tog(1); chk("R7 running phase keeps old length", last_len, 10);
    wait_tog(1); chk("R7 next phase new length", last_len, 3);

    // R4 R5 R6 R9: rejected writes
    wr(10); wait_tog(3);
    wr(0);
    chk("R5 zero sets err", int'(err_o), 1);
    chk("R5 zero keeps cfg", int'(cfg_n_o), 4);
    wait_tog(2); chk("R9 phase unchanged", last_len, 5);
    wr(7);
    chk("R4 odd keeps cfg", int'(cfg_n_o), 4);
    chk("R6 err sticky", int'(err_o), 1);
    wr(63);
    chk("R4 odd keeps cfg", int'(cfg_n_o), 4);
    wr(66);
    chk("R5 above 64 keeps cfg", int'(cfg_n_o), 4);
    chk("R6 err sticky", int'(err_o), 1);
    wr(65);
    chk("R5 65 keeps cfg", int'(cfg_n_o), 4);
    wr(127);
    chk("R5 127 keeps cfg", int'(cfg_n_o), 4);
    wait_tog(2); chk("R9 phase unchanged", last_len, 5);
    repeat (5) @(negedge clk_i);
    chk("R6 err held without writes", int'(err_o), 1);
    wr(12);
    chk("R6 err cleared", int'(err_o), 0);
    chk("R3 stored field", int'(cfg_n_o), 5);
    wr(3);
    chk("R4 odd sets err", int'(err_o), 1);
    chk("R4 odd keeps cfg", int'(cfg_n_o), 5);

    // R8: every helper input
    for (int q = 0; q < 128; q++) begin
      @(negedge clk_i); req_ratio_i = 7'(q); #1;
      chk("R8 rounding", int'(rnd_ratio_o), (q % 2 == 1) ? q + 1 : q);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule